// File: doc/BRIEF.md
# Inter-Processor Doorbell and Message Interrupt Unit

This unit lets one processor ring a numbered doorbell on any set of processors, and it collects message-signalled interrupts as bits in a shared doorbell register. A single write-only trigger register carries both the doorbell number and a bitmap of target processors. Each processor owns an inbound doorbell register and a doorbell mask. A processor's interrupt line is high while any of its inbound bits is both set and enabled. Trigger writes that carry the message flag go to a separate message doorbell register. Its own interrupt line is high while any bit in it is set.

Software reaches the unit over a simple 32-bit register port. A processor-index input selects which processor's private registers a per-processor access reaches. Pending bits are cleared by writing a value that has zeros in the bits to clear and ones elsewhere. Software learns the next doorbell to service from a read-only lowest-pending register. That register returns the smallest pending index, or the code 0x3FF when nothing is pending.

Top module: `db_doorbell_unit`

## Requirements
- R1: After reset every inbound register, every mask and the message doorbell register read 0, both lowest-pending registers read 0x3FF, every interrupt output is low and `bus_rdata` is 0.
- R2: A write to the trigger register (offset 0x004) with bit 5 clear sets bit `wdata[4:0]` in the inbound register of every processor i whose `wdata[8+i]` is 1. All other inbound bits are unchanged.
- R3: A trigger write with bit 5 clear and all target bits `wdata[8+i]` zero changes no register.
- R4: A trigger write with bit 5 set is a message. It sets bit `wdata[4:0]` of the message doorbell register (read at offset 0x040), ignores the target bits and leaves every inbound register unchanged.
- R5: A write to the inbound register (per-processor offset 0x108) of processor `bus_cpu` ANDs it with `wdata`. Bits written as 0 clear and bits written as 1 keep their value.
- R6: The mask register (per-processor offset 0x10C) is written as a whole. `cpu_irq_o[i]` equals the OR of inbound i AND mask i. The output shows the new state from the clock edge that takes the write.
- R7: A write to the message doorbell register ANDs it with `wdata`. `msi_irq_o` is high exactly while that register is non-zero, and it changes from the edge that takes the write.
- R8: The per-processor lowest-pending register (offset 0x110) returns the index of the lowest set bit of inbound AND mask, or 0x3FF when there is none.
- R9: The message lowest-pending register (offset 0x044) returns the index of the lowest set bit of the message doorbell register, or 0x3FF when it is zero.
- R10: A read with `bus_rd` high in one cycle presents its data on `bus_rdata` in the next cycle. In a cycle after no read, and for the trigger and unmapped offsets, `bus_rdata` is 0.
- R11: A per-processor access with `bus_cpu` not below the processor count changes nothing and reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 9 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | CPU_W (3) | Processor whose private registers are accessed |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| cpu_irq_o | output | NUM_CPUS (4) | Doorbell interrupt per processor |
| msi_irq_o | output | 1 | Message doorbell interrupt |

## Verification
On every cycle the assertions check four things. A decoded trigger lands in the targeted inbound bits and in the message bits. Clear writes never leave a bit that was written as zero. The interrupt lines track the enabled pending state. Empty-target, message-flagged and out-of-range accesses leave the processor registers unchanged. The priority encoder checks its own result as it produces it. Only the bench scenarios show the full register contents through reads over long mixes of triggers, clears and mask changes. They also show the exact lowest-pending codes, the read latency and the reset values.

// File: rtl/db_pkg.sv
package db_pkg;
    localparam int unsigned DB_N      = 32;
    localparam int unsigned IDX_W     = $clog2(DB_N);
    localparam int unsigned ADDR_W    = 9;
    localparam int unsigned FLAG_BIT  = 5;
    localparam int unsigned TGT_LSB   = 8;
    localparam logic [31:0] NONE_CODE = 32'h0000_03FF;

    localparam logic [ADDR_W-1:0] OFF_TRIG    = 9'h004;
    localparam logic [ADDR_W-1:0] OFF_MSI     = 9'h040;
    localparam logic [ADDR_W-1:0] OFF_MSI_LOW = 9'h044;
    localparam logic [ADDR_W-1:0] OFF_INB     = 9'h108;
    localparam logic [ADDR_W-1:0] OFF_MASK    = 9'h10C;
    localparam logic [ADDR_W-1:0] OFF_LOW     = 9'h110;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TRIG,
        SEL_MSI,
        SEL_MSI_LOW,
        SEL_INB,
        SEL_MASK,
        SEL_LOW
    } reg_sel_e;
endpackage

// File: rtl/db_access_decode.sv
module db_access_decode
    import db_pkg::*;
#(
    parameter int unsigned NUM_CPUS = 4,
    parameter int unsigned CPU_W    = $clog2(NUM_CPUS) + 1
) (
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    input  logic [CPU_W-1:0]    bus_cpu,
    output reg_sel_e            sel,
    output logic                cpu_ok,
    output logic [NUM_CPUS-1:0] trig_cpu,
    output logic [IDX_W-1:0]    set_idx,
    output logic                msi_set,
    output logic [NUM_CPUS-1:0] inb_clr,
    output logic [NUM_CPUS-1:0] mask_wr,
    output logic                msi_clr
);
    logic trig_wr;
    logic is_msg;

    always_comb begin
        unique case (bus_addr)
            OFF_TRIG:    sel = SEL_TRIG;
            OFF_MSI:     sel = SEL_MSI;
            OFF_MSI_LOW: sel = SEL_MSI_LOW;
            OFF_INB:     sel = SEL_INB;
            OFF_MASK:    sel = SEL_MASK;
            OFF_LOW:     sel = SEL_LOW;
            default:     sel = SEL_NONE;
        endcase
    end

    assign cpu_ok   = (bus_cpu < CPU_W'(NUM_CPUS));
    assign trig_wr  = bus_wr && (sel == SEL_TRIG);
    assign is_msg   = bus_wdata[FLAG_BIT];
    assign set_idx  = bus_wdata[IDX_W-1:0];
    assign msi_set  = trig_wr && is_msg;
    assign trig_cpu = (trig_wr && !is_msg) ? bus_wdata[TGT_LSB +: NUM_CPUS] : '0;
    assign msi_clr  = bus_wr && (sel == SEL_MSI);

    for (genvar g = 0; g < NUM_CPUS; g++) begin : g_sel
        logic hit;
        assign hit        = bus_wr && cpu_ok && (bus_cpu == CPU_W'(g));
        assign inb_clr[g] = hit && (sel == SEL_INB);
        assign mask_wr[g] = hit && (sel == SEL_MASK);
    end
endmodule

// File: rtl/db_cpu_bank.sv
module db_cpu_bank
    import db_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic             mask_en,
    input  logic [DB_N-1:0]  wdata,
    output logic [DB_N-1:0]  inb_q,
    output logic [DB_N-1:0]  mask_q,
    output logic             irq_o
);
    logic [DB_N-1:0] inb_nxt;
    logic [DB_N-1:0] mask_nxt;

    always_comb begin
        inb_nxt = clr_en ? (inb_q & wdata) : inb_q;
        if (set_en) begin
            inb_nxt[set_idx] = 1'b1;
        end
        mask_nxt = mask_en ? wdata : mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inb_q  <= '0;
            mask_q <= '0;
            irq_o  <= 1'b0;
        end else begin
            inb_q  <= inb_nxt;
            mask_q <= mask_nxt;
            irq_o  <= |(inb_nxt & mask_nxt);
        end
    end

    assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> inb_q[$past(set_idx)]);

    assert_clear_and_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> ((inb_q & ~$past(wdata)) == '0));

    assert_irq_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|(inb_q & mask_q)));
endmodule

// File: rtl/db_msi_bank.sv
module db_msi_bank
    import db_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [DB_N-1:0]  wdata,
    output logic [DB_N-1:0]  msi_q,
    output logic             irq_o
);
    logic [DB_N-1:0] msi_nxt;

    always_comb begin
        msi_nxt = clr_en ? (msi_q & wdata) : msi_q;
        if (set_en) begin
            msi_nxt[set_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msi_q <= '0;
            irq_o <= 1'b0;
        end else begin
            msi_q <= msi_nxt;
            irq_o <= |msi_nxt;
        end
    end

    assert_msi_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> msi_q[$past(set_idx)]);

    assert_msi_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> ((msi_q & ~$past(wdata)) == '0));

    assert_msi_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (msi_q != '0));
endmodule

// File: rtl/db_lowest_enc.sv
module db_lowest_enc
    import db_pkg::*;
(
    input  logic [DB_N-1:0] vec,
    output logic [31:0]     code
);
    always_comb begin
        code = NONE_CODE;
        for (int i = DB_N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                code = 32'(i);
            end
        end
    end

    always_comb begin
        if (vec == '0) begin
            assert_none_code_R8: assert (code == NONE_CODE);
        end else begin
            assert_lowest_hit_R8: assert (vec[code[IDX_W-1:0]] &&
                ((vec & ((DB_N'(1) << code[IDX_W-1:0]) - DB_N'(1))) == '0));
        end
    end
endmodule

// File: rtl/db_doorbell_unit.sv
module db_doorbell_unit
    import db_pkg::*;
#(
    parameter int unsigned NUM_CPUS = 4,
    parameter int unsigned CPU_W    = $clog2(NUM_CPUS) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [8:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    input  logic [CPU_W-1:0]    bus_cpu,
    output logic [31:0]         bus_rdata,
    output logic [NUM_CPUS-1:0] cpu_irq_o,
    output logic                msi_irq_o
);
    reg_sel_e                       sel;
    logic                           cpu_ok;
    logic [NUM_CPUS-1:0]            trig_cpu;
    logic [IDX_W-1:0]               set_idx;
    logic                           msi_set;
    logic [NUM_CPUS-1:0]            inb_clr;
    logic [NUM_CPUS-1:0]            mask_wr;
    logic                           msi_clr;
    logic [NUM_CPUS-1:0][DB_N-1:0]  inb_all;
    logic [NUM_CPUS-1:0][DB_N-1:0]  mask_all;
    logic [NUM_CPUS-1:0][31:0]      low_all;
    logic [DB_N-1:0]                msi_q;
    logic [31:0]                    msi_low;
    logic [31:0]                    rd_val;

    db_access_decode #(.NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W)) u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_cpu  (bus_cpu),
        .sel      (sel),
        .cpu_ok   (cpu_ok),
        .trig_cpu (trig_cpu),
        .set_idx  (set_idx),
        .msi_set  (msi_set),
        .inb_clr  (inb_clr),
        .mask_wr  (mask_wr),
        .msi_clr  (msi_clr)
    );

    for (genvar g = 0; g < NUM_CPUS; g++) begin : g_cpu
        db_cpu_bank u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (trig_cpu[g]),
            .set_idx(set_idx),
            .clr_en (inb_clr[g]),
            .mask_en(mask_wr[g]),
            .wdata  (bus_wdata),
            .inb_q  (inb_all[g]),
            .mask_q (mask_all[g]),
            .irq_o  (cpu_irq_o[g])
        );
        db_lowest_enc u_low (
            .vec (inb_all[g] & mask_all[g]),
            .code(low_all[g])
        );
    end

    db_msi_bank u_msi (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (msi_set),
        .set_idx(set_idx),
        .clr_en (msi_clr),
        .wdata  (bus_wdata),
        .msi_q  (msi_q),
        .irq_o  (msi_irq_o)
    );

    db_lowest_enc u_msi_low (
        .vec (msi_q),
        .code(msi_low)
    );

    always_comb begin
        rd_val = '0;
        unique case (sel)
            SEL_MSI:     rd_val = msi_q;
            SEL_MSI_LOW: rd_val = msi_low;
            SEL_INB, SEL_MASK, SEL_LOW: begin
                for (int i = 0; i < NUM_CPUS; i++) begin
                    if (cpu_ok && bus_cpu == CPU_W'(i)) begin
                        rd_val = (sel == SEL_INB)  ? inb_all[i] :
                                 (sel == SEL_MASK) ? mask_all[i] : low_all[i];
                    end
                end
            end
            default:     rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= bus_rd ? rd_val : '0;
        end
    end

    assert_empty_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_TRIG && !bus_wdata[FLAG_BIT] &&
         bus_wdata[TGT_LSB +: NUM_CPUS] == '0)
        |=> ($stable(inb_all) && $stable(msi_q)));

    assert_msg_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_TRIG && bus_wdata[FLAG_BIT]) |=> $stable(inb_all));

    assert_bad_cpu_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_cpu >= CPU_W'(NUM_CPUS) && bus_addr != OFF_TRIG)
        |=> ($stable(inb_all) && $stable(mask_all)));

    assert_idle_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/tb_db_doorbell_unit.sv
module tb_db_doorbell_unit;
    localparam int NCPU = 4;
    localparam int CW   = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [8:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [CW-1:0]   bus_cpu = '0;
    logic [31:0]     bus_rdata;
    logic [NCPU-1:0] cpu_irq_o;
    logic            msi_irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_inb  [NCPU];
    logic [31:0] m_mask [NCPU];
    logic [31:0] m_msi;

    always #10 clk = ~clk;

    db_doorbell_unit #(.NUM_CPUS(NCPU), .CPU_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
        .bus_rdata(bus_rdata), .cpu_irq_o(cpu_irq_o), .msi_irq_o(msi_irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lowest(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return 32'(i);
        return 32'h3FF;
    endfunction

    function automatic logic [31:0] exp_read(input logic [8:0] a, input logic [CW-1:0] c);
        bit ok = (int'(c) < NCPU);
        case (a)
            9'h040: return m_msi;
            9'h044: return lowest(m_msi);
            9'h108: return ok ? m_inb[c] : 32'h0;
            9'h10C: return ok ? m_mask[c] : 32'h0;
            9'h110: return ok ? lowest(m_inb[c] & m_mask[c]) : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_irq();
        logic [31:0] r = '0;
        for (int i = 0; i < NCPU; i++) r[i] = |(m_inb[i] & m_mask[i]);
        return r;
    endfunction

    task automatic wr(input logic [8:0] a, input logic [31:0] d, input logic [CW-1:0] c);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_cpu = c;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            9'h004: begin
                if (d[5]) m_msi[d[4:0]] = 1'b1;
                else for (int i = 0; i < NCPU; i++) if (d[8+i]) m_inb[i][d[4:0]] = 1'b1;
            end
            9'h040: m_msi = m_msi & d;
            9'h108: if (int'(c) < NCPU) m_inb[c] = m_inb[c] & d;
            9'h10C: if (int'(c) < NCPU) m_mask[c] = d;
            default: ;
        endcase
        chk("R6 cpu_irq_o after write", 32'(cpu_irq_o), exp_irq());
        chk("R7 msi_irq_o after write", 32'(msi_irq_o), 32'(m_msi != 0));
    endtask

    task automatic rd(input string req, input logic [8:0] a, input logic [CW-1:0] c);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_cpu = c;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(req, bus_rdata, exp_read(a, c));
    endtask

    task automatic rd_all(input string req);
        rd(req, 9'h040, 0);
        rd(req, 9'h044, 0);
        for (int i = 0; i < NCPU; i++) begin
            rd(req, 9'h108, CW'(i));
            rd(req, 9'h10C, CW'(i));
            rd(req, 9'h110, CW'(i));
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NCPU; i++) begin m_inb[i] = '0; m_mask[i] = '0; end
        m_msi = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", bus_rdata, 32'h0);
        chk("R1 cpu_irq_o", 32'(cpu_irq_o), 32'h0);
        chk("R1 msi_irq_o", 32'(msi_irq_o), 32'h0);
        rd_all("R1 reset registers");

        // R6 mask enable with nothing pending keeps irq low
        wr(9'h10C, 32'hFFFF_FFFF, 0);
        // R2 trigger to cpu0 and cpu2, doorbell 7
        wr(9'h004, 32'h0000_0507, 0);
        rd("R2 inbound cpu0", 9'h108, 0);
        rd("R2 inbound cpu2", 9'h108, 2);
        rd("R2 inbound cpu1 untouched", 9'h108, 1);
        chk("R6 cpu2 masked irq low", 32'(cpu_irq_o[2]), 32'h0);
        // R3 empty bitmap
        wr(9'h004, 32'h0000_0013, 0);
        rd_all("R3 empty target no effect");
        // R4 message write sets bit 9 of message register, targets ignored
        wr(9'h004, 32'h0000_0F29, 0);
        rd_all("R4 message doorbell");
        // R8 lowest: set bit 12 and 3 on cpu0
        wr(9'h004, 32'h0000_010C, 0);
        wr(9'h004, 32'h0000_0103, 0);
        rd("R8 lowest cpu0", 9'h110, 0);
        // R5 clear bit 3 only
        wr(9'h108, ~32'h8, 0);
        rd("R5 inbound after clear", 9'h108, 0);
        rd("R8 lowest after clear", 9'h110, 0);
        // R9 message lowest and R7 clear
        wr(9'h004, 32'h0000_0024, 0);
        rd("R9 message lowest", 9'h044, 0);
        wr(9'h040, ~32'h10, 0);
        rd("R9 message lowest after clear", 9'h044, 0);
        wr(9'h040, 32'h0, 0);
        chk("R7 msi_irq_o cleared", 32'(msi_irq_o), 32'h0);
        // R11 out-of-range processor
        wr(9'h10C, 32'h1234_5678, 5);
        wr(9'h108, 32'h0, 6);
        rd("R11 out-of-range read", 9'h10C, 5);
        rd_all("R11 state unchanged");
        // R10 trigger and unmapped offsets read 0, idle cycle gives 0
        rd("R10 trigger reads zero", 9'h004, 0);
        rd("R10 unmapped reads zero", 9'h0A0, 0);
        @(negedge clk);
        chk("R10 idle rdata", bus_rdata, 32'h0);

        // random mix
        for (int n = 0; n < 600; n++) begin
            int op = int'($urandom_range(0, 9));
            logic [CW-1:0] c = CW'($urandom_range(0, 5));
            logic [31:0] d;
            case (op)
                0, 1, 2: begin
                    d = {16'h0, 4'h0, 4'($urandom), 3'($urandom), 5'($urandom)};
                    if (op == 2) d[5] = 1'b1; else d[5] = 1'b0;
                    wr(9'h004, d, 0);
                end
                3: wr(9'h108, ~(32'h1 << $urandom_range(0, 31)), c);
                4: wr(9'h108, $urandom, c);
                5: wr(9'h10C, ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom, c);
                6: wr(9'h040, ~(32'h1 << $urandom_range(0, 31)), 0);
                7: rd("R8 random lowest", 9'h110, c);
                8: rd("R2 random inbound", 9'h108, c);
                default: rd("R9 random message lowest", 9'h044, 0);
            endcase
        end
        rd_all("R5 final state");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule